// File: doc/BRIEF.md
# Even-Parity Serial Port with DMA Request/Acknowledge Pacing

This block is a full-duplex asynchronous serial port. It exchanges bytes with a DMA controller through request/acknowledge pairs and raises no interrupts. A fixed divider turns the system clock into an oversampling tick. Each serial bit lasts a fixed number of those ticks. A frame is one low start bit, eight data bits sent least significant bit first, one even-parity bit and one high stop bit.

On the receive side, a complete frame with a valid stop bit is placed in an output register. The block then raises a DMA request, but only while the uplink enable input is high. The acknowledge takes the byte and withdraws the request. A parity mismatch sets a sticky error flag, and a CPU clear strobe resets it. The error never changes how frames are sequenced or delivered.

On the transmit side, a DMA request is raised whenever the one-byte holding register is empty. An acknowledge writes the offered byte into the holding register. The byte moves into the shift register at the next oversampling tick that finds the line idle, and this frees the holding register for the next byte while the current frame is still on the wire.

Top module: `dma_serial_port`

## Requirements
- R1: `tx_o` is high after reset and whenever the transmitter is idle. A transmitted frame is, in time order: a start bit of 0, data bits 0 through 7, the parity bit, and a stop bit of 1.
- R2: The transmitted parity bit comes directly after data bit 7. Its value is the XOR of the eight data bits, so the data bits and the parity bit together hold an even number of ones.
- R3: The oversampling tick occurs once every DIV system clocks. Every serial bit lasts OVS ticks. With DIV=16 and OVS=16, the start bit stays on `tx_o` for exactly 256 clocks, and `tx_o` changes only on the clock that follows a tick.
- R4: When a frame with a high stop bit completes while `uplink_en_i` is 1, `rx_dreq_o` goes to 1 and `rx_data_o` holds the byte. If `rx_dack_ni` is low for one clock, `rx_dreq_o` is 0 on the following clock.
- R5: A frame that completes while `uplink_en_i` is 0 raises no request, and setting the enable afterwards does not raise one either. Lowering `uplink_en_i` while a request is pending withdraws the request.
- R6: A received parity bit that does not equal the XOR of the received data bits sets `perr_o` to 1, whether or not the uplink is enabled. The byte is still delivered, and `perr_o` stays 1 across later good frames until `perr_clr_i` is high for one clock.
- R7: A frame whose stop bit is sampled low is discarded and raises no request. The next correct frame is still received correctly.
- R8: If a second frame completes before the first byte has been acknowledged, `rx_dreq_o` stays 1 and `rx_data_o` holds the second byte.
- R9: `tx_dreq_o` is 1 while the holding register is empty. A low `tx_dack_ni` loads `tx_data_i` and makes `tx_dreq_o` 0 on the next clock. `tx_dreq_o` returns to 1 during the start bit of that byte's frame.
- R10: While `rst_ni` is low, `tx_o`=1, `rx_dreq_o`=0, `tx_dreq_o`=1 and `perr_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| uplink_en_i | input | 1 | Allows receive DMA requests |
| rx_dreq_o | output | 1 | Receive DMA request, active high |
| rx_dack_ni | input | 1 | Receive DMA acknowledge, active low |
| rx_data_o | output | 8 | Last received byte |
| tx_dreq_o | output | 1 | Transmit DMA request, active high |
| tx_dack_ni | input | 1 | Transmit DMA acknowledge, active low |
| tx_data_i | input | 8 | Byte written on transmit acknowledge |
| perr_o | output | 1 | Sticky receive parity error flag |
| perr_clr_i | input | 1 | Clears the parity error flag, active high |

## Verification
The hardest situations to reach are those in which a receive frame is broken or a byte is left unread. These are a parity bit that disagrees with its data, a stop bit held low, and a second frame that lands on an unacknowledged byte. The bench drives the serial line bit by bit from its own frame builder. It can flip the parity bit, force the stop level, and choose to skip the acknowledge between two frames. Each of these is followed by a good frame, which shows that the receiver recovered.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  localparam int unsigned FRAME_BITS = 11;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  function automatic logic even_par(input logic [7:0] d);
    return ^d;
  endfunction
endpackage

// File: rtl/dsp_tick_gen.sv
module dsp_tick_gen #(
  parameter int unsigned DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dsp_rx.sv
module dsp_rx
  import dsp_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rx_i,
  input  logic       uplink_en_i,
  input  logic       dack_ni,
  input  logic       perr_clr_i,
  output logic       dreq_o,
  output logic [7:0] data_o,
  output logic       perr_o
);
  localparam int unsigned CW = $clog2(OVS);
  localparam logic [CW-1:0] HALF = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  rx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    idx_q;
  logic [7:0]    sh_q, data_q;
  logic          rx_m, rx_s, prev_q, pend_q, perr_q;
  logic          at_last, done_stb, par_stb;

  assign at_last  = tick_i && (cnt_q == LAST);
  assign done_stb = at_last && (state_q == RX_STOP);
  assign par_stb  = at_last && (state_q == RX_PAR);

  // two-flop synchronizer, previous sample kept per tick for edge detect
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_m   <= 1'b1;
      rx_s   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      rx_m <= rx_i;
      rx_s <= rx_m;
      if (tick_i) prev_q <= rx_s;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
    end else if (tick_i) begin
      unique case (state_q)
        RX_IDLE: if (prev_q && !rx_s) begin
          state_q <= RX_START;
          cnt_q   <= '0;
        end
        RX_START: if (cnt_q == HALF) begin
          cnt_q   <= '0;
          idx_q   <= '0;
          state_q <= rx_s ? RX_IDLE : RX_DATA;
        end else cnt_q <= cnt_q + 1'b1;
        RX_DATA: if (cnt_q == LAST) begin
          cnt_q <= '0;
          sh_q  <= {rx_s, sh_q[7:1]};
          if (idx_q == 3'd7) state_q <= RX_PAR;
          else               idx_q   <= idx_q + 1'b1;
        end else cnt_q <= cnt_q + 1'b1;
        RX_PAR: if (cnt_q == LAST) begin
          cnt_q   <= '0;
          state_q <= RX_STOP;
        end else cnt_q <= cnt_q + 1'b1;
        RX_STOP: if (cnt_q == LAST) begin
          cnt_q   <= '0;
          state_q <= RX_IDLE;
        end else cnt_q <= cnt_q + 1'b1;
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  // delivery: a new byte overwrites an unread one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      data_q <= '0;
    end else if (done_stb && rx_s && uplink_en_i) begin
      pend_q <= 1'b1;
      data_q <= sh_q;
    end else if (!dack_ni || !uplink_en_i) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 perr_q <= 1'b0;
    else if (par_stb && (rx_s != even_par(sh_q))) perr_q <= 1'b1;
    else if (perr_clr_i)                         perr_q <= 1'b0;
  end

  assign dreq_o = pend_q;
  assign data_o = data_q;
  assign perr_o = perr_q;
endmodule

// File: rtl/dsp_tx.sv
module dsp_tx
  import dsp_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       dack_ni,
  input  logic [7:0] data_i,
  output logic       dreq_o,
  output logic       tx_o
);
  localparam int unsigned CW = $clog2(OVS);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [3:0] LAST_BIT = 4'(FRAME_BITS - 1);

  logic [7:0]            hold_q;
  logic                  full_q, busy_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic [CW-1:0]         cnt_q;
  logic [3:0]            nb_q;
  logic                  move;

  // transfer into the shifter only on a tick so every bit is OVS ticks long
  assign move = tick_i && !busy_q && full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      full_q <= 1'b0;
    end else if (move) begin
      full_q <= 1'b0;
    end else if (!full_q && !dack_ni) begin
      hold_q <= data_i;
      full_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
      nb_q   <= '0;
    end else if (move) begin
      busy_q <= 1'b1;
      sh_q   <= {1'b1, even_par(hold_q), hold_q, 1'b0};
      cnt_q  <= '0;
      nb_q   <= '0;
    end else if (tick_i && busy_q) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        sh_q  <= {1'b1, sh_q[FRAME_BITS-1:1]};
        if (nb_q == LAST_BIT) busy_q <= 1'b0;
        else                  nb_q   <= nb_q + 1'b1;
      end else cnt_q <= cnt_q + 1'b1;
    end
  end

  assign dreq_o = !full_q;
  assign tx_o   = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/dma_serial_port.sv
module dma_serial_port #(
  parameter int unsigned DIV = 16,
  parameter int unsigned OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  output logic       tx_o,
  input  logic       uplink_en_i,
  output logic       rx_dreq_o,
  input  logic       rx_dack_ni,
  output logic [7:0] rx_data_o,
  output logic       tx_dreq_o,
  input  logic       tx_dack_ni,
  input  logic [7:0] tx_data_i,
  output logic       perr_o,
  input  logic       perr_clr_i
);
  logic os_tick;

  dsp_tick_gen #(.DIV(DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (os_tick)
  );

  dsp_rx #(.OVS(OVS)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (os_tick),
    .rx_i        (rx_i),
    .uplink_en_i (uplink_en_i),
    .dack_ni     (rx_dack_ni),
    .perr_clr_i  (perr_clr_i),
    .dreq_o      (rx_dreq_o),
    .data_o      (rx_data_o),
    .perr_o      (perr_o)
  );

  dsp_tx #(.OVS(OVS)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (os_tick),
    .dack_ni (tx_dack_ni),
    .data_i  (tx_data_i),
    .dreq_o  (tx_dreq_o),
    .tx_o    (tx_o)
  );
endmodule

// File: rtl/dsp_checks.sv
module dsp_checks (
  input logic clk_i,
  input logic rst_ni,
  input logic os_tick,
  input logic rx_dreq_o,
  input logic rx_dack_ni,
  input logic uplink_en_i,
  input logic tx_dreq_o,
  input logic tx_dack_ni,
  input logic tx_o,
  input logic perr_o,
  input logic perr_clr_i
);
  assert_rx_req_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_dreq_o) |-> ($past(!rx_dack_ni) || $past(!uplink_en_i)));

  assert_rx_req_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_dreq_o) |-> $past(uplink_en_i));

  assert_perr_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(perr_o) |-> $past(perr_clr_i));

  assert_tx_req_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_dreq_o) |-> $past(!tx_dack_ni));

  assert_tx_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tx_o) |-> $past(os_tick));
endmodule

bind dma_serial_port dsp_checks u_chk (.*);

// File: tb/dma_serial_port_tb.sv
module dma_serial_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BIT = 16;  // DIV=1, OVS=16 for dut_i

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rx = 1'b1, uplink_en = 1'b1, rx_dack_n = 1'b1, tx_dack_n = 1'b1, perr_clr = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx, rx_dreq, tx_dreq, perr;
  logic [7:0] rx_data;
  logic tx2, rx_dreq2, tx_dreq2, perr2, tx2_dack_n = 1'b1;
  logic [7:0] rx_data2;
  int n_total = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dma_serial_port #(.DIV(1), .OVS(16)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .rx_i(rx), .tx_o(tx), .uplink_en_i(uplink_en),
    .rx_dreq_o(rx_dreq), .rx_dack_ni(rx_dack_n), .rx_data_o(rx_data),
    .tx_dreq_o(tx_dreq), .tx_dack_ni(tx_dack_n), .tx_data_i(tx_data),
    .perr_o(perr), .perr_clr_i(perr_clr));

  dma_serial_port dut_div_i (
    .clk_i(clk), .rst_ni(rst_ni), .rx_i(1'b1), .tx_o(tx2), .uplink_en_i(1'b1),
    .rx_dreq_o(rx_dreq2), .rx_dack_ni(1'b1), .rx_data_o(rx_data2),
    .tx_dreq_o(tx_dreq2), .tx_dack_ni(tx2_dack_n), .tx_data_i(8'h55),
    .perr_o(perr2), .perr_clr_i(1'b0));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input bit flip_par, input bit stop_v);
    logic [10:0] f;
    f = {stop_v, (^d) ^ flip_par, d, 1'b0};
    for (int i = 0; i < 11; i++) begin
      rx = f[i];
      repeat (BIT) @(negedge clk);
    end
    rx = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic rx_ack();
    rx_dack_n = 1'b0;
    @(negedge clk);
    rx_dack_n = 1'b1;
  endtask

  task automatic clr_perr();
    perr_clr = 1'b1;
    @(negedge clk);
    perr_clr = 1'b0;
  endtask

  task automatic tx_one(input logic [7:0] d);
    logic [10:0] got, exp;
    while (!tx_dreq) @(negedge clk);
    tx_dack_n = 1'b0;
    tx_data = d;
    @(negedge clk);
    tx_dack_n = 1'b1;
    check("R9 request drops after ack", tx_dreq, 0);
    while (tx !== 1'b0) @(negedge clk);
    repeat (7) @(negedge clk);
    got[0] = tx;
    check("R9 request back during start bit", tx_dreq, 1);
    for (int i = 1; i < 11; i++) begin
      repeat (BIT) @(negedge clk);
      got[i] = tx;
    end
    exp = {1'b1, ^d, d, 1'b0};
    check("R1 start/data/stop bits", {got[10], got[8:0]}, {exp[10], exp[8:0]});
    check("R2 parity after bit 7", got[9], exp[9]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 tx idle", tx, 1);
    check("R10 rx request", rx_dreq, 0);
    check("R10 tx request", tx_dreq, 1);
    check("R10 parity flag", perr, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 tx idle high", tx, 1);

    // R4 sweep over every byte value
    for (int d = 0; d < 256; d++) begin
      send_frame(8'(d), 1'b0, 1'b1);
      check("R4 request and data", {rx_dreq, rx_data}, {1'b1, 8'(d)});
      rx_ack();
      check("R4 request cleared by ack", rx_dreq, 0);
    end
    check("R6 no error on good frames", perr, 0);

    // R6 parity error: delivered, sticky, cleared by strobe
    send_frame(8'hA5, 1'b1, 1'b1);
    check("R6 error flag set", perr, 1);
    check("R6 byte still delivered", {rx_dreq, rx_data}, {1'b1, 8'hA5});
    rx_ack();
    send_frame(8'h3C, 1'b0, 1'b1);
    check("R6 flag sticky over good frame", perr, 1);
    check("R6 good frame after error", {rx_dreq, rx_data}, {1'b1, 8'h3C});
    rx_ack();
    clr_perr();
    check("R6 flag cleared", perr, 0);

    // R5 uplink gating
    uplink_en = 1'b0;
    send_frame(8'h81, 1'b1, 1'b1);
    check("R5 no request while disabled", rx_dreq, 0);
    check("R6 error latched while disabled", perr, 1);
    uplink_en = 1'b1;
    @(negedge clk);
    check("R5 enable does not revive byte", rx_dreq, 0);
    clr_perr();
    send_frame(8'h42, 1'b0, 1'b1);
    check("R5 request with enable", rx_dreq, 1);
    uplink_en = 1'b0;
    @(negedge clk);
    check("R5 request withdrawn", rx_dreq, 0);
    uplink_en = 1'b1;

    // R7 bad stop bit
    send_frame(8'h99, 1'b0, 1'b0);
    repeat (2 * BIT) @(negedge clk);
    check("R7 bad stop dropped", rx_dreq, 0);
    send_frame(8'h66, 1'b0, 1'b1);
    check("R7 recovery frame", {rx_dreq, rx_data}, {1'b1, 8'h66});
    rx_ack();

    // R8 overwrite
    send_frame(8'h12, 1'b0, 1'b1);
    send_frame(8'hED, 1'b0, 1'b1);
    check("R8 second byte overwrites", {rx_dreq, rx_data}, {1'b1, 8'hED});
    rx_ack();
    check("R8 ack clears", rx_dreq, 0);

    // transmit sweep
    for (int d = 0; d < 256; d++) tx_one(8'(d));
    repeat (2 * BIT) @(negedge clk);
    check("R1 idle high after frames", tx, 1);

    // R3 divided timing on default instance
    check("R9 divided instance request", tx_dreq2, 1);
    tx2_dack_n = 1'b0;
    @(negedge clk);
    tx2_dack_n = 1'b1;
    while (tx2 !== 1'b0) @(negedge clk);
    begin
      int n;
      n = 0;
      while (tx2 === 1'b0 && n < 1000) begin
        n++;
        @(negedge clk);
      end
      check("R3 start bit clocks", n, 256);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_total++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end
endmodule